// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits beside the main command arbiter of an SDRAM controller and keeps the memory array refreshed. A free-running interval timer produces one refresh obligation every `T_REF_CYC / REF_COUNT` clock cycles. Each obligation adds to a bounded debt, and any debt above zero raises a bus request. Once the arbiter grants the bus, the sequencer closes open rows with a precharge-all if needed and then issues refreshes back to back until the debt is paid. A refresh leaves every bank idle, so no precharge is needed between refreshes. While the sequencer holds the bus, every cycle without a command carries a NOP on the command pins.

The same sequencer handles self-refresh. A requester raises `sr_req`. Once granted, the sequencer precharges if needed and optionally runs a full burst of `REF_COUNT` refreshes. It then issues the self-refresh entry command, which uses the refresh encoding with CKE dropped on the same edge, and raises `sr_ack`. CKE stays low until the requester withdraws `sr_req` and the clock is reported stable. CKE then rises with a NOP, the sequencer waits `TRC` cycles, and it runs the optional second refresh burst before it releases the bus.

Top module: `sdram_refresh_seq`

## Requirements
- R1: One refresh obligation accrues every `T_REF_CYC/REF_COUNT` cycles after reset. `bus_req` is high whenever the debt is non-zero or `sr_req` is high, and it stays high while a sequence is in progress.
- R2: The debt saturates at `DEBT_MAX` and never wraps. `ref_urgent` is high exactly when the debt equals `DEBT_MAX`.
- R3: No command other than NOP appears on the pins while the sequencer is idle and `bus_gnt` is low.
- R4: If `banks_open` is high when a sequence starts, the first command is precharge-all: CKE=1, RAS_n=0, CAS_n=1, WE_n=0, A10=1. The next command follows exactly `TRP` cycles later.
- R5: Refresh is encoded CKE=1, RAS_n=0, CAS_n=0, WE_n=1. Consecutive refreshes are spaced exactly `TRFC` cycles apart, with no precharge between them.
- R6: Once granted, the sequencer pays off the whole debt, lowers `ref_urgent`, and then drops `bus_req`.
- R7: Outside self-refresh, every cycle without a command drives NOP: CKE=1 and RAS_n, CAS_n and WE_n all high.
- R8: Self-refresh entry issues `REF_COUNT` refreshes (when `SR_BURST`=1) followed by the entry command. The entry command is CKE=0, RAS_n=0, CAS_n=0, WE_n=1, with CKE falling on that same edge, and `sr_ack` rises with it.
- R9: In self-refresh, CKE stays low and `bus_gnt`/`banks_open` have no effect. Exit does not begin while `sr_req` is high or `clk_stable` is low.
- R10: On exit, CKE rises together with a NOP and `sr_ack` falls. The first command comes exactly `TRC` cycles later. `REF_COUNT` refreshes follow, and then the bus is released with the debt cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_gnt | input | 1 | Arbiter grants the command bus |
| banks_open | input | 1 | At least one bank has an active row |
| sr_req | input | 1 | Request to enter and remain in self-refresh |
| clk_stable | input | 1 | Memory clock is running and stable |
| bus_req | output | 1 | Request for the command bus |
| ref_urgent | output | 1 | Debt is at its limit; the arbiter should grant promptly |
| sr_ack | output | 1 | Memory is in self-refresh |
| cmd_cke | output | 1 | Clock-enable pin |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10; high selects all banks on precharge |

## Verification
The in-RTL assertions check several rules on every cycle:
- every CKE fall carries the entry encoding, and every CKE rise carries a NOP;
- CKE never rises unless the clock was stable and the request had been withdrawn;
- no command appears without a prior bus request;
- an idle sequencer drives NOP;
- the debt counter decrements and saturates correctly, and `ref_urgent` implies `bus_req`.

Other properties only show up in the bench's scenarios: the exact spacing of TRP, TRFC and TRC between commands, the presence or absence of the leading precharge, the length of both refresh bursts, and the release of the bus with the debt cleared. The bench checks these by comparing the decoded command stream and its cycle gaps against a queue of expected commands.

// File: rtl/sdram_rfs_pkg.sv
package sdram_rfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RFC,
    ST_SELF,
    ST_XWAIT
  } rfs_state_e;

  typedef enum logic [1:0] {
    PH_NORM,
    PH_ENTER,
    PH_LEAVE
  } rfs_phase_e;

  typedef enum logic [1:0] {
    STEP_REF,
    STEP_SRE,
    STEP_DONE
  } rfs_step_e;

  typedef struct packed {
    logic cke;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sdr_cmd_t;

  function automatic sdr_cmd_t nop_cmd(input logic cke);
    return '{cke: cke, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  endfunction

  function automatic sdr_cmd_t ref_cmd();
    return '{cke: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
  endfunction

  function automatic sdr_cmd_t pre_all_cmd();
    return '{cke: 1'b1, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  endfunction

  function automatic sdr_cmd_t sre_cmd();
    return '{cke: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int PERIOD = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(PERIOD - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: ticks are single-cycle pulses
  p_tick_pulse_r1: assert property (@(posedge clk) disable iff (rst || clr)
    tick |=> !tick || (PERIOD == 1));

endmodule

// File: rtl/rfs_debt_counter.sv
module rfs_debt_counter #(
  parameter int DEBT_MAX = 8,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [DW-1:0] debt,
  output logic          urgent
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      debt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
        2'b01:   if (debt != '0) debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  assign urgent = (debt == DW'(DEBT_MAX));

  p_debt_dec_r6: assert property (@(posedge clk) disable iff (rst || clr)
    (dec && !inc && debt != '0) |=> (debt == $past(debt) - 1'b1));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst || clr)
    (inc && !dec && urgent) |=> urgent);

endmodule

// File: rtl/rfs_wait_timer.sv
module rfs_wait_timer #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  output logic          done
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // R5: a non-zero load always holds off the next step
  p_load_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !done);

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_rfs_pkg::*;
#(
  parameter int T_REF_CYC = 6_400_000,
  parameter int REF_COUNT = 4096,
  parameter int TRFC      = 7,
  parameter int TRP       = 3,
  parameter int TRC       = 7,
  parameter int DEBT_MAX  = 8,
  parameter bit SR_BURST  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_gnt,
  input  logic banks_open,
  input  logic sr_req,
  input  logic clk_stable,
  output logic bus_req,
  output logic ref_urgent,
  output logic sr_ack,
  output logic cmd_cke,
  output logic cmd_ras_n,
  output logic cmd_cas_n,
  output logic cmd_we_n,
  output logic cmd_a10
);
  localparam int REFI     = T_REF_CYC / REF_COUNT;
  localparam int WAIT_MAX = (TRFC > TRP) ? ((TRFC > TRC) ? TRFC : TRC)
                                         : ((TRP > TRC) ? TRP : TRC);
  localparam int WW       = $clog2(WAIT_MAX + 1);
  localparam int BW       = $clog2(REF_COUNT + 1);
  localparam int DW       = $clog2(DEBT_MAX + 1);
  localparam int BURST_N  = SR_BURST ? REF_COUNT : 0;

  rfs_state_e     state;
  rfs_phase_e     phase;
  rfs_step_e      step;
  logic [BW-1:0]  burst_left;
  sdr_cmd_t       cmd_q;
  logic           ack_q;
  logic           tick;
  logic           clr;
  logic [DW-1:0]  debt;
  logic           urgent;
  logic           debt_dec;
  logic           wt_load;
  logic           wt_done;
  logic [WW-1:0]  wt_val;
  logic           start;
  logic           step_now;
  logic           exit_ok;

  assign clr = (phase != PH_NORM);

  rfs_interval_timer #(.PERIOD(REFI)) u_interval (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .tick (tick)
  );

  rfs_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .inc    (tick),
    .dec    (debt_dec),
    .debt   (debt),
    .urgent (urgent)
  );

  rfs_wait_timer #(.WW(WW)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (wt_load),
    .load_val (wt_val),
    .done     (wt_done)
  );

  assign start    = (state == ST_IDLE) && bus_gnt && (sr_req || debt != '0);
  assign step_now = ((state == ST_PRE) || (state == ST_RFC) || (state == ST_XWAIT)) && wt_done;
  assign exit_ok  = (state == ST_SELF) && !sr_req && clk_stable;

  always_comb begin
    case (phase)
      PH_ENTER: step = (burst_left != '0) ? STEP_REF : STEP_SRE;
      PH_LEAVE: step = (burst_left != '0) ? STEP_REF : STEP_DONE;
      default:  step = (debt != '0) ? STEP_REF : STEP_DONE;
    endcase
  end

  assign debt_dec = step_now && (step == STEP_REF) && (phase == PH_NORM);

  always_comb begin
    wt_load = 1'b0;
    wt_val  = '0;
    if (start) begin
      wt_load = 1'b1;
      wt_val  = banks_open ? WW'(TRP - 1) : '0;
    end else if (step_now && step == STEP_REF) begin
      wt_load = 1'b1;
      wt_val  = WW'(TRFC - 1);
    end else if (exit_ok) begin
      wt_load = 1'b1;
      wt_val  = WW'(TRC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= PH_NORM;
      burst_left <= '0;
      cmd_q      <= nop_cmd(1'b1);
      ack_q      <= 1'b0;
    end else begin
      cmd_q <= nop_cmd(1'b1);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_PRE;
            if (sr_req) begin
              phase      <= PH_ENTER;
              burst_left <= BW'(BURST_N);
            end
            if (banks_open) cmd_q <= pre_all_cmd();
          end
        end
        ST_SELF: begin
          cmd_q <= nop_cmd(1'b0);
          if (exit_ok) begin
            cmd_q      <= nop_cmd(1'b1);
            ack_q      <= 1'b0;
            phase      <= PH_LEAVE;
            burst_left <= BW'(BURST_N);
            state      <= ST_XWAIT;
          end
        end
        default: begin
          if (step_now) begin
            case (step)
              STEP_REF: begin
                cmd_q <= ref_cmd();
                state <= ST_RFC;
                if (phase != PH_NORM) burst_left <= burst_left - 1'b1;
              end
              STEP_SRE: begin
                cmd_q <= sre_cmd();
                ack_q <= 1'b1;
                state <= ST_SELF;
              end
              default: begin
                state <= ST_IDLE;
                phase <= PH_NORM;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign bus_req    = (state != ST_IDLE) || (debt != '0) || sr_req;
  assign ref_urgent = urgent;
  assign sr_ack     = ack_q;
  assign cmd_cke    = cmd_q.cke;
  assign cmd_ras_n  = cmd_q.ras_n;
  assign cmd_cas_n  = cmd_q.cas_n;
  assign cmd_we_n   = cmd_q.we_n;
  assign cmd_a10    = cmd_q.a10;

  initial begin
    p_params_r5: assert (TRFC >= 1 && TRP >= 1 && TRC >= 1 && REFI >= 1 && DEBT_MAX >= 1);
  end

  p_urgent_req_r2: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> bus_req);

  p_sre_encoding_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_cke) |-> (!cmd_ras_n && !cmd_cas_n && cmd_we_n && sr_ack));

  p_exit_nop_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_cke) |-> (cmd_ras_n && cmd_cas_n && cmd_we_n && !sr_ack));

  p_exit_guard_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_cke) |-> ($past(clk_stable) && !$past(sr_req)));

  p_cmd_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ras_n || !cmd_cas_n || !cmd_we_n) |-> $past(bus_req));

  p_idle_nop_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |->
      (cmd_cke && cmd_ras_n && cmd_cas_n && cmd_we_n));

endmodule

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_refresh_seq_tb;
  localparam int T_REF_CYC = 320;
  localparam int REF_COUNT = 8;
  localparam int TRFC      = 4;
  localparam int TRP       = 2;
  localparam int TRC       = 6;
  localparam int DEBT_MAX  = 3;

  localparam int EV_PRE = 1;
  localparam int EV_REF = 2;
  localparam int EV_SRE = 3;
  localparam int EV_SRX = 4;
  localparam int EV_BAD = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_gnt = 1'b0;
  logic banks_open = 1'b0;
  logic sr_req = 1'b0;
  logic clk_stable = 1'b1;
  logic bus_req, ref_urgent, sr_ack;
  logic cmd_cke, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  int    exp_kind[$];
  int    exp_gap[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  sdram_refresh_seq #(
    .T_REF_CYC(T_REF_CYC), .REF_COUNT(REF_COUNT), .TRFC(TRFC), .TRP(TRP),
    .TRC(TRC), .DEBT_MAX(DEBT_MAX), .SR_BURST(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_gnt(bus_gnt), .banks_open(banks_open),
    .sr_req(sr_req), .clk_stable(clk_stable), .bus_req(bus_req),
    .ref_urgent(ref_urgent), .sr_ack(sr_ack), .cmd_cke(cmd_cke),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_a10(cmd_a10)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int gap, input string tag);
    exp_kind.push_back(kind);
    exp_gap.push_back(gap);
    exp_tag.push_back(tag);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: decode the pins, pop the scoreboard and compare kind and gap
  int last_ev  = 0;
  bit prev_cke = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      int ev;
      ev = 0;
      if (prev_cke && !cmd_cke && !cmd_ras_n && !cmd_cas_n && cmd_we_n) ev = EV_SRE;
      else if (prev_cke && !cmd_cke) ev = EV_BAD;
      else if (!prev_cke && cmd_cke) ev = (cmd_ras_n && cmd_cas_n && cmd_we_n) ? EV_SRX : EV_BAD;
      else if (cmd_cke && !cmd_ras_n && cmd_cas_n && !cmd_we_n && cmd_a10) ev = EV_PRE;
      else if (cmd_cke && !cmd_ras_n && !cmd_cas_n && cmd_we_n) ev = EV_REF;
      else if (!(cmd_ras_n && cmd_cas_n && cmd_we_n)) ev = EV_BAD;
      if (ev != 0) begin
        int gap;
        gap = cyc - last_ev;
        last_ev = cyc;
        if (exp_kind.size() == 0) begin
          chk(1'b0, "R3/R9 unexpected command", ev, 0);
        end else begin
          int k; int g; string t;
          k = exp_kind.pop_front();
          g = exp_gap.pop_front();
          t = exp_tag.pop_front();
          chk(ev == k, {t, " kind"}, ev, k);
          if (g != 0) chk(gap == g, {t, " gap"}, gap, g);
        end
      end
      prev_cke = cmd_cke;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_drain(input string tag);
    int t;
    t = 0;
    while (exp_kind.size() != 0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk(exp_kind.size() == 0, {tag, " expected commands seen"}, exp_kind.size(), 0);
  endtask

  task automatic wait_req();
    int t;
    t = 0;
    while (!bus_req && t < 400) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    finish_run();
  end

  initial begin
    wait_cyc(4);
    // Reset state (R7, R1, R2)
    chk(cmd_cke && cmd_ras_n && cmd_cas_n && cmd_we_n, "R7 reset NOP", cmd_ras_n, 1);
    chk(!bus_req, "R1 reset bus_req", bus_req, 0);
    chk(!ref_urgent && !sr_ack, "R2 reset urgent/ack", ref_urgent, 0);
    rst = 1'b0;

    // Scenario A: debt accrues, urgent, precharge then drain (R1 R2 R4 R5 R6)
    wait_cyc(30);
    chk(!bus_req, "R1 no request before interval", bus_req, 0);
    wait_cyc(20);
    chk(bus_req, "R1 request after one interval", bus_req, 1);
    chk(!ref_urgent, "R2 not urgent at debt 1", ref_urgent, 0);
    wait_cyc(80);
    chk(ref_urgent, "R2 urgent at limit", ref_urgent, 1);
    push(EV_PRE, 0, "R4 precharge first");
    push(EV_REF, TRP, "R4 refresh after TRP");
    push(EV_REF, TRFC, "R5 refresh spacing");
    push(EV_REF, TRFC, "R5 refresh spacing");
    banks_open = 1'b1;
    bus_gnt    = 1'b1;
    wait_drain("R6");
    wait_cyc(8);
    chk(!bus_req, "R6 bus released after drain", bus_req, 1'b0);
    chk(!ref_urgent, "R6 urgent cleared", ref_urgent, 0);
    chk(cmd_cke && cmd_ras_n && cmd_cas_n && cmd_we_n, "R7 idle NOP", cmd_ras_n, 1);
    bus_gnt = 1'b0;

    // Scenario B: closed banks, no precharge; waiting without grant (R3 R5)
    banks_open = 1'b0;
    wait_req();
    wait_cyc(5);
    chk(bus_req, "R3 request held without grant", bus_req, 1);
    push(EV_REF, 0, "R5 refresh without precharge");
    bus_gnt = 1'b1;
    wait_drain("R5");
    wait_cyc(8);
    chk(!bus_req, "R6 released after single refresh", bus_req, 0);
    bus_gnt = 1'b0;

    // Scenario C: self-refresh with open banks (R8 R9 R10)
    banks_open = 1'b1;
    sr_req     = 1'b1;
    push(EV_PRE, 0, "R8 entry precharge");
    push(EV_REF, TRP, "R8 entry burst");
    for (int i = 1; i < REF_COUNT; i++) push(EV_REF, TRFC, "R8 entry burst");
    push(EV_SRE, TRFC, "R8 entry command");
    bus_gnt = 1'b1;
    wait_drain("R8");
    wait_cyc(2);
    chk(sr_ack, "R8 ack in self-refresh", sr_ack, 1);
    chk(!cmd_cke, "R8 CKE low", cmd_cke, 0);
    bus_gnt    = 1'b0;
    banks_open = 1'b0;
    wait_cyc(10);
    bus_gnt    = 1'b1;
    wait_cyc(10);
    chk(!cmd_cke && sr_ack, "R9 grant/banks ignored in self-refresh", cmd_cke, 0);
    clk_stable = 1'b0;
    sr_req     = 1'b0;
    wait_cyc(20);
    chk(!cmd_cke, "R9 no exit while clock unstable", cmd_cke, 0);
    chk(sr_ack, "R9 ack held while clock unstable", sr_ack, 1);
    bus_gnt = 1'b0;
    push(EV_SRX, 0, "R10 exit");
    push(EV_REF, TRC, "R10 first command after TRC");
    for (int i = 1; i < REF_COUNT; i++) push(EV_REF, TRFC, "R10 exit burst");
    clk_stable = 1'b1;
    wait_cyc(2);
    chk(cmd_cke && !sr_ack, "R10 CKE high, ack low", sr_ack, 0);
    wait_drain("R10");
    wait_cyc(8);
    chk(!bus_req, "R10 bus released, debt cleared", bus_req, 0);

    // Scenario D: self-refresh with banks closed; request held (R8 R9 R10)
    sr_req = 1'b1;
    push(EV_REF, 0, "R8 entry burst, no precharge");
    for (int i = 1; i < REF_COUNT; i++) push(EV_REF, TRFC, "R8 entry burst");
    push(EV_SRE, TRFC, "R8 entry command");
    bus_gnt = 1'b1;
    wait_drain("R8");
    bus_gnt = 1'b0;
    wait_cyc(15);
    chk(!cmd_cke, "R9 no exit while request held", cmd_cke, 0);
    push(EV_SRX, 0, "R10 exit");
    push(EV_REF, TRC, "R10 first command after TRC");
    for (int i = 1; i < REF_COUNT; i++) push(EV_REF, TRFC, "R10 exit burst");
    sr_req = 1'b0;
    wait_drain("R10");
    wait_cyc(8);
    chk(!bus_req && !sr_ack, "R10 released after second exit", bus_req, 0);
    chk(cmd_cke && cmd_ras_n && cmd_cas_n && cmd_we_n, "R7 final NOP", cmd_ras_n, 1);

    finish_run();
  end

endmodule